// File: doc/BRIEF.md
# Power-of-Two Block-Average Decimator

This block reduces a stream of signed samples to one output for every 2^M accepted inputs. The output is the mean of the samples in the block that just ended. It is built as a first-order integrator-comb pair. An accumulator adds every accepted sample at the input rate. A counter marks the last sample of each block. On that sample a differencing stage subtracts the accumulator value taken at the previous block boundary. It then shifts the difference right by M. The result is a 2^M-point average that needs no sample history.

M comes from an input pin and can be set while the block runs, so one instance can trade output rate against smoothing. The block reads the pin during reset and again at each block boundary. A change therefore never splits a block. The accumulator is DW+MMAX bits wide and wraps in two's complement; the wrap cancels in the subtraction. A constant input comes out at the same value, and the average tracks a step in the input with a delay of about 2^(M-1) input samples.

Top module: `blockavg_decimator`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, out_valid is 0 and out_data is 0.
- R2: out_valid is high for exactly one cycle: the cycle after the clock edge that accepts the 2^M-th sample of a block. No other cycle has out_valid high. The first block after reset produces an output like any other block.
- R3: Each output equals the sum of the 2^M samples in its block divided by 2^M, rounded toward minus infinity. This is an arithmetic right shift by M.
- R4: A cycle with in_valid low does not advance the block count and does not change the accumulated sum.
- R5: Results stay exact when the accumulator wraps, for example after hundreds of full-scale positive or negative samples.
- R6: m_sel is sampled during reset and on the clock edge that accepts the last sample of a block. Changes to m_sel at any other time have no effect on the block in progress.
- R7: With M = 0, every accepted sample comes out unchanged on the following cycle.
- R8: An m_sel value above MMAX acts as MMAX.
- R9: A constant input value gives exactly that value at the output (unity DC gain).
- R10: out_data holds its last value on every cycle where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample on in_data is accepted on this edge |
| in_data | input | DW | Signed input sample |
| m_sel | input | $clog2(MMAX+1) | Block length exponent M (block = 2^M samples) |
| out_valid | output | 1 | One-cycle strobe marking a new average |
| out_data | output | DW | Signed block average, held between strobes |

## Verification
Two cases are hard to reach from the ports. The first is accumulator wrap-around: it only happens after many full-scale samples at the largest block length. The bench drives long runs of the most positive value and then the most negative value at M = MMAX. It expects exact results across the wrap. The second is an m_sel change in the middle of a block. The bench changes m_sel on every cycle of a gapped stream, so boundaries land on both valid and idle patterns. Its model picks up the new length only at the cycle that ends a block.

// File: rtl/blockavg_pkg.sv
package blockavg_pkg;

  // Limit a requested exponent to the largest supported block length.
  function automatic int clamp_m(input int m, input int mmax);
    return (m > mmax) ? mmax : m;
  endfunction

  // Width of the block counter; never below one bit.
  function automatic int cnt_width(input int mmax);
    return (mmax > 0) ? mmax : 1;
  endfunction

endpackage

// File: rtl/blockavg_integrator.sv
module blockavg_integrator #(
  parameter int DW = 16,
  parameter int IW = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [IW-1:0] acc_next
);

  logic signed [IW-1:0] acc_q;
  logic signed [IW-1:0] din_ext;

  assign din_ext  = {{(IW-DW){din[DW-1]}}, din};
  // Sum including the sample on the input this cycle; wraps modulo 2^IW.
  assign acc_next = acc_q + din_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_next;
    end
  end

endmodule

// File: rtl/blockavg_decim_ctrl.sv
module blockavg_decim_ctrl #(
  parameter int MMAX = 6,
  parameter int MW   = 3,
  parameter int CW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [MW-1:0] m_sel,
  output logic [MW-1:0] m_act,
  output logic [CW-1:0] blk_cnt,
  output logic          boundary
);

  logic [MW-1:0] m_req;
  logic [CW-1:0] blk_mask;

  assign m_req    = MW'(blockavg_pkg::clamp_m(int'(m_sel), MMAX));
  assign blk_mask = CW'((1 << m_act) - 1);
  assign boundary = in_valid && (blk_cnt == blk_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_cnt <= '0;
      m_act   <= m_req;
    end else if (boundary) begin
      blk_cnt <= '0;
      m_act   <= m_req;
    end else if (in_valid) begin
      blk_cnt <= blk_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/blockavg_comb.sv
module blockavg_comb #(
  parameter int DW   = 16,
  parameter int IW   = 22,
  parameter int MMAX = 6,
  parameter int MW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tap_en,
  input  logic signed [IW-1:0] tap,
  input  logic [MW-1:0]        shift,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  logic signed [IW-1:0] prev_q;
  logic signed [IW-1:0] diff;
  logic signed [DW-1:0] opts [MMAX+1];

  // Difference of two wrapped taps is exact as long as the block sum fits IW.
  assign diff = tap - prev_q;

  // One scaled candidate per legal exponent; the active one is muxed out.
  for (genvar k = 0; k <= MMAX; k++) begin : g_scale
    assign opts[k] = DW'(diff >>> k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= tap_en;
      if (tap_en) begin
        prev_q   <= tap;
        out_data <= opts[shift];
      end
    end
  end

endmodule

// File: rtl/blockavg_decimator.sv
module blockavg_decimator #(
  parameter int DW   = 16,
  parameter int MMAX = 6,
  parameter int MW   = $clog2(MMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [MW-1:0]        m_sel,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  localparam int IW = DW + MMAX;
  localparam int CW = blockavg_pkg::cnt_width(MMAX);

  logic signed [IW-1:0] acc_next;
  logic [MW-1:0]        m_act;
  logic [CW-1:0]        blk_cnt;
  logic                 boundary;

  blockavg_integrator #(.DW(DW), .IW(IW)) u_integ (
    .clk      (clk),
    .rst      (rst),
    .en       (in_valid),
    .din      (in_data),
    .acc_next (acc_next)
  );

  blockavg_decim_ctrl #(.MMAX(MMAX), .MW(MW), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .m_sel    (m_sel),
    .m_act    (m_act),
    .blk_cnt  (blk_cnt),
    .boundary (boundary)
  );

  blockavg_comb #(.DW(DW), .IW(IW), .MMAX(MMAX), .MW(MW)) u_comb (
    .clk       (clk),
    .rst       (rst),
    .tap_en    (boundary),
    .tap       (acc_next),
    .shift     (m_act),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/blockavg_decimator_chk.sv
module blockavg_decimator_chk #(
  parameter int DW   = 16,
  parameter int MMAX = 6,
  parameter int MW   = 3,
  parameter int CW   = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [MW-1:0] m_act,
  input logic [CW-1:0] blk_cnt,
  input logic          boundary
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  assert_strobe_source_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(boundary));

  assert_boundary_emits_R2: assert property (@(posedge clk) disable iff (rst)
    boundary |=> out_valid);

  assert_idle_no_count_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(blk_cnt));

  assert_m_only_at_edge_R6: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(m_act));

  assert_m_clamped_R8: assert property (@(posedge clk) disable iff (rst)
    m_act <= MW'(MMAX));

  assert_hold_data_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

endmodule

bind blockavg_decimator blockavg_decimator_chk #(
  .DW(DW), .MMAX(MMAX), .MW(MW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .m_act     (m_act),
  .blk_cnt   (blk_cnt),
  .boundary  (boundary)
);

// File: tb/blockavg_decimator_tb_top.sv
module blockavg_decimator_tb_top;

  localparam int DW   = 16;
  localparam int MMAX = 6;
  localparam int MW   = 3;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic [MW-1:0]        m_sel = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_data;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  int                   cur_m;
  int                   blk[$];
  bit                   exp_valid;
  logic signed [DW-1:0] exp_data;

  always #10 clk = ~clk;

  blockavg_decimator #(.DW(DW), .MMAX(MMAX)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .m_sel     (m_sel),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic int lim(input int m);
    return (m > MMAX) ? MMAX : m;
  endfunction

  // Compare outputs for the edge just passed, drive the next inputs,
  // advance the model across the coming edge, then wait for the next negedge.
  task automatic tick(input bit v, input int d, input int m, input string tag);
    longint sum;
    checks++;
    if (out_valid !== exp_valid) begin
      fails++;
      $display("FAIL R2: out_valid=%0b expected %0b", out_valid, exp_valid);
    end
    checks++;
    if (out_data !== exp_data) begin
      fails++;
      $display("FAIL %s: out_data=%0d expected %0d",
               exp_valid ? tag : "R10", out_data, exp_data);
    end
    in_valid = v;
    in_data  = DW'(d);
    m_sel    = MW'(m);
    exp_valid = 1'b0;
    if (v) begin
      blk.push_back(d);
      if (blk.size() == (1 << cur_m)) begin
        sum = 0;
        foreach (blk[i]) sum += blk[i];
        exp_data  = DW'(sum >>> cur_m);
        exp_valid = 1'b1;
        blk.delete();
        cur_m = lim(m);
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input int m);
    rst = 1'b1;
    in_valid = 1'b0;
    m_sel = MW'(m);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_m = lim(m);
    blk.delete();
    exp_valid = 1'b0;
    exp_data = '0;
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      fails++;
      $display("FAIL R1: out_valid=%0b out_data=%0d expected 0 0", out_valid, out_data);
    end
  endtask

  function automatic int rnd();
    return int'($urandom % 65536) - 32768;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    // R1 and R3: reset then contiguous random blocks at M=2
    do_reset(2);
    for (int i = 0; i < 40; i++) tick(1'b1, rnd(), 2, "R3");
    // R3: floor rounding on a negative sum (-1/4 -> -1)
    tick(1'b1, -1, 2, "R3");
    for (int i = 0; i < 3; i++) tick(1'b1, 0, 2, "R3");
    tick(1'b0, 0, 3, "R3");
    // R4: gapped stream at M=3 (the boundary above loaded M=2; next loads 3)
    for (int i = 0; i < 200; i++) tick(($urandom % 2) == 1, rnd(), 3, "R4");
    // R6: m_sel changes every cycle, with gaps
    for (int i = 0; i < 400; i++) tick(($urandom % 4) != 0, rnd(), int'($urandom % 5), "R6");
    // R7: move to M=0 and run pass-through
    do_reset(0);
    for (int i = 0; i < 30; i++) tick(1'b1, rnd(), 0, "R7");
    for (int i = 0; i < 20; i++) tick(($urandom % 2) == 1, rnd(), 0, "R7");
    // R8: m_sel=7 clamps to MMAX=6
    do_reset(7);
    for (int i = 0; i < 200; i++) tick(1'b1, rnd(), 7, "R8");
    // R5: full-scale runs force accumulator wrap at M=MMAX
    do_reset(MMAX);
    for (int i = 0; i < 640; i++) tick(1'b1, 32767, MMAX, "R5");
    for (int i = 0; i < 640; i++) tick(1'b1, -32768, MMAX, "R5");
    for (int i = 0; i < 256; i++) tick(1'b1, (i % 2 == 0) ? 32767 : -32768, MMAX, "R5");
    // R9: DC input at M=4 reproduces itself
    do_reset(4);
    for (int i = 0; i < 96; i++) tick(1'b1, -1234, 4, "R9");
    for (int i = 0; i < 64; i++) tick(1'b1, 777, 4, "R9");
    // R10: long idle stretch, data must hold
    for (int i = 0; i < 20; i++) tick(1'b0, rnd(), 4, "R10");
    tick(1'b0, 0, 4, "R10");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule